// File: doc/BRIEF.md
# PCI Power Management Capability Registers

This block holds the power management capability of one PCI function, together with the interrupt and bus-timing fields of the standard header dword at byte offset 3Ch. A configuration agent reaches it through a dword-addressed port that has byte enables, a write strobe and combinational read data. The block drives the function's current power state to the rest of the chip. It also drives an active-low wake request (PME#) with a separate output enable, so the pin can be wired open-drain.

The wake status bit and the wake enable bit sit in an auxiliary-power reset domain, so they survive a PCI reset. The power state and the interrupt line are cleared by the PCI reset. Two fields of the capabilities word depend on whether auxiliary power is present. A wake-event pulse from the detection logic sets the status bit when it is allowed to. The minimum-grant and maximum-latency fields come from an EEPROM loader when it reports valid data, and otherwise read 20h.

Top module: `pm_cap_regs`

## Requirements
- R1: The capability header dword (default dword address 10h) reads 01h in bits 7:0 (capability ID) and 00h in bits 15:8 (next pointer, end of list).
- R2: Bits 31:16 of the capability header dword read C0A2h when `aux_present` is 1 and 4022h when it is 0. With auxiliary power absent, bit 15 and bits 8:6 of that word read zero.
- R3: In the control/status dword (capability address + 1), bit 15 is the wake status. Writing 1 to it with byte enable 1 set clears it. Writing 0 leaves it unchanged. A wake event in the same cycle as a clearing write leaves it set.
- R4: Bit 8 of the control/status dword is the wake enable and is read/write under byte enable 1. The wake status is set by a wake event regardless of the enable.
- R5: Bits 1:0 of the control/status dword hold the power state and are output on `pwr_state`. A write under byte enable 0 with value 00 (D0) or 11 (D3hot) is stored. A value of 01 or 10 is discarded and the state is kept.
- R6: Bits 31:16, 14:9 and 7:2 of the control/status dword read zero. Any address other than the three mapped dwords reads zero.
- R7: A PCI reset returns the power state to D0 and the interrupt line to 00h, and leaves the wake status and enable unchanged. An auxiliary reset clears the wake status and enable.
- R8: The header dword 0Fh reads the interrupt line in bits 7:0 (read/write) and 01h in bits 15:8. Bits 23:16 hold the minimum grant and bits 31:24 the maximum latency. Each of these two takes the EEPROM value when `eeprom_valid` is 1, and 20h otherwise.
- R9: `pme_oe` is 1 and `pme_n` is 0 exactly when both wake status and wake enable are 1. Otherwise `pme_oe` is 0 and `pme_n` is 1.
- R10: A `wake_pulse` sets the wake status only when `aux_present` is 1 or the power state is D3hot. In any other case it has no effect.
- R11: A write changes only the bytes whose byte enable is set. Writes that arrive while the PCI reset is asserted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| pci_rst_n | input | 1 | PCI reset, active low, asynchronous |
| aux_rst_n | input | 1 | Auxiliary-power reset for the sticky bits, active low, asynchronous |
| aux_present | input | 1 | Auxiliary supply is present |
| wake_pulse | input | 1 | One-cycle wake event from the detection logic |
| eeprom_valid | input | 1 | EEPROM loader has supplied grant/latency values |
| eeprom_min_grant | input | 8 | Minimum grant value from the EEPROM |
| eeprom_max_lat | input | 8 | Maximum latency value from the EEPROM |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| pwr_state | output | 2 | Current power state (00 D0, 11 D3hot) |
| pme_n | output | 1 | Wake request, active low |
| pme_oe | output | 1 | Output enable for the wake request pin |

## Verification
The properties assume that `wake_pulse` and `cfg_wr` are synchronous to `clk`. They also assume that `aux_present` changes only between clock edges, and that `pci_rst_n` and `aux_rst_n` are deasserted away from the clock edge. The stimulus therefore drives every input half a cycle after the sampling edge and releases both resets in the same way. It issues writes only while the PCI reset is released, except for one deliberate write during reset. Wake events are single-cycle pulses that are placed both inside and outside the conditions that allow them.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam logic [1:0] PS_D0    = 2'b00;
    localparam logic [1:0] PS_D3HOT = 2'b11;
    localparam logic [7:0] CAP_ID_PM   = 8'h01;
    localparam logic [7:0] CAP_NEXT    = 8'h00;
    localparam logic [7:0] INT_PIN_A   = 8'h01;
    localparam logic [7:0] GL_DEFAULT  = 8'h20;

    typedef struct packed {
        logic sts;
        logic en;
    } sticky_t;

    typedef struct packed {
        logic [1:0] ps;
        logic [7:0] line;
    } pci_regs_t;

    // capability word: D3cold/D3hot wake, aux current, DSI, version 2
    function automatic logic [15:0] cap_word(input logic aux);
        logic [15:0] w;
        w        = 16'h0000;
        w[15]    = aux;
        w[14]    = 1'b1;
        w[8:6]   = aux ? 3'b010 : 3'b000;
        w[5]     = 1'b1;
        w[2:0]   = 3'b010;
        return w;
    endfunction
endpackage

// File: rtl/pm_sticky.sv
module pm_sticky
    import pm_pkg::*;
(
    input  logic clk,
    input  logic aux_rst_n,
    input  logic wr_csr,
    input  logic be_hi,
    input  logic wd_sts,
    input  logic wd_en,
    input  logic wake_ok,
    output logic sts,
    output logic en
);
    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_csr && be_hi) begin
            st_d.en = wd_en;
            if (wd_sts) st_d.sts = 1'b0;
        end
        if (wake_ok) st_d.sts = 1'b1;
    end

    always_ff @(posedge clk or negedge aux_rst_n) begin
        if (!aux_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign en  = st_q.en;
endmodule

// File: rtl/pm_pci_regs.sv
module pm_pci_regs
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       pci_rst_n,
    input  logic       wr_csr,
    input  logic       wr_int,
    input  logic       be_lo,
    input  logic [7:0] wd_lo,
    output logic [1:0] ps,
    output logic [7:0] line
);
    pci_regs_t rg_d, rg_q;
    logic      ps_legal;

    always_comb begin
        ps_legal = (wd_lo[1:0] == PS_D0) || (wd_lo[1:0] == PS_D3HOT);
        rg_d = rg_q;
        if (wr_csr && be_lo && ps_legal) rg_d.ps   = wd_lo[1:0];
        if (wr_int && be_lo)             rg_d.line = wd_lo;
    end

    always_ff @(posedge clk or negedge pci_rst_n) begin
        if (!pci_rst_n) rg_q <= '{ps: PS_D0, line: 8'h00};
        else            rg_q <= rg_d;
    end

    assign ps   = rg_q.ps;
    assign line = rg_q.line;
endmodule

// File: rtl/pm_rd_mux.sv
module pm_rd_mux
    import pm_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter logic [ADDR_W-1:0] CAP_DW = 6'h10,
    parameter logic [ADDR_W-1:0] INT_DW = 6'h0F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              aux_present,
    input  logic              eeprom_valid,
    input  logic [7:0]        eeprom_min_grant,
    input  logic [7:0]        eeprom_max_lat,
    input  logic              sts,
    input  logic              en,
    input  logic [1:0]        ps,
    input  logic [7:0]        line,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] CSR_DW = CAP_DW + 1'b1;
    logic [7:0] min_g, max_l;

    always_comb begin
        min_g = eeprom_valid ? eeprom_min_grant : GL_DEFAULT;
        max_l = eeprom_valid ? eeprom_max_lat   : GL_DEFAULT;
        rdata = 32'h0;
        if (addr == INT_DW)      rdata = {max_l, min_g, INT_PIN_A, line};
        else if (addr == CAP_DW) rdata = {cap_word(aux_present), CAP_NEXT, CAP_ID_PM};
        else if (addr == CSR_DW) rdata = {16'h0, sts, 6'b0, en, 6'b0, ps};
    end
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
    import pm_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter logic [ADDR_W-1:0] CAP_DW = 6'h10,
    parameter logic [ADDR_W-1:0] INT_DW = 6'h0F
) (
    input  logic              clk,
    input  logic              pci_rst_n,
    input  logic              aux_rst_n,
    input  logic              aux_present,
    input  logic              wake_pulse,
    input  logic              eeprom_valid,
    input  logic [7:0]        eeprom_min_grant,
    input  logic [7:0]        eeprom_max_lat,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_wr,
    output logic [31:0]       cfg_rdata,
    output logic [1:0]        pwr_state,
    output logic              pme_n,
    output logic              pme_oe
);
    localparam logic [ADDR_W-1:0] CSR_DW = CAP_DW + 1'b1;

    logic       wr_ok, wr_csr, wr_int, wake_ok;
    logic       pme_sts, pme_en;
    logic [1:0] ps;
    logic [7:0] line;

    assign wr_ok   = cfg_wr && pci_rst_n;
    assign wr_csr  = wr_ok && (cfg_addr == CSR_DW);
    assign wr_int  = wr_ok && (cfg_addr == INT_DW);
    assign wake_ok = wake_pulse && (aux_present || (ps == PS_D3HOT));

    pm_sticky u_sticky (
        .clk(clk), .aux_rst_n(aux_rst_n), .wr_csr(wr_csr), .be_hi(cfg_be[1]),
        .wd_sts(cfg_wdata[15]), .wd_en(cfg_wdata[8]), .wake_ok(wake_ok),
        .sts(pme_sts), .en(pme_en)
    );

    pm_pci_regs u_pci (
        .clk(clk), .pci_rst_n(pci_rst_n), .wr_csr(wr_csr), .wr_int(wr_int),
        .be_lo(cfg_be[0]), .wd_lo(cfg_wdata[7:0]), .ps(ps), .line(line)
    );

    pm_rd_mux #(.ADDR_W(ADDR_W), .CAP_DW(CAP_DW), .INT_DW(INT_DW)) u_mux (
        .addr(cfg_addr), .aux_present(aux_present), .eeprom_valid(eeprom_valid),
        .eeprom_min_grant(eeprom_min_grant), .eeprom_max_lat(eeprom_max_lat),
        .sts(pme_sts), .en(pme_en), .ps(ps), .line(line), .rdata(cfg_rdata)
    );

    assign pwr_state = ps;
    assign pme_oe    = pme_sts && pme_en;
    assign pme_n     = ~pme_oe;
endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter logic [ADDR_W-1:0] CAP_DW = 6'h10
) (
    input logic              clk,
    input logic              pci_rst_n,
    input logic              aux_rst_n,
    input logic              aux_present,
    input logic              wake_pulse,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic              cfg_wr,
    input logic [1:0]        pwr_state,
    input logic              pme_n,
    input logic              pme_oe,
    input logic              pme_sts
);
    logic csr_wr;
    assign csr_wr = cfg_wr && (cfg_addr == CAP_DW + 1'b1);

    a_r5_reserved_state_kept: assert property (@(posedge clk) disable iff (!pci_rst_n)
        (csr_wr && cfg_be[0] && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10))
        |=> $stable(pwr_state));

    a_r3_clear_on_one: assert property (@(posedge clk) disable iff (!pci_rst_n || !aux_rst_n)
        (csr_wr && cfg_be[1] && cfg_wdata[15] && !wake_pulse) |=> !pme_sts);

    a_r3_no_set_without_wake: assert property (@(posedge clk) disable iff (!aux_rst_n)
        (!wake_pulse && !pme_sts) |=> !pme_sts);

    a_r10_wake_sets: assert property (@(posedge clk) disable iff (!aux_rst_n || !pci_rst_n)
        (wake_pulse && (aux_present || pwr_state == 2'b11)) |=> pme_sts);

    a_r7_sticky_in_pci_reset: assert property (@(posedge clk) disable iff (!aux_rst_n)
        (!pci_rst_n && !wake_pulse) |=> $stable(pme_sts));

    a_r9_pin_pair: assert property (@(posedge clk) disable iff (!aux_rst_n)
        pme_oe != pme_n);
endmodule

bind pm_cap_regs pm_cap_regs_chk #(.ADDR_W(ADDR_W), .CAP_DW(CAP_DW)) u_chk (
    .clk(clk), .pci_rst_n(pci_rst_n), .aux_rst_n(aux_rst_n), .aux_present(aux_present),
    .wake_pulse(wake_pulse), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .pwr_state(pwr_state), .pme_n(pme_n), .pme_oe(pme_oe),
    .pme_sts(pme_sts)
);

// File: tb/pm_cap_regs_tb_top.sv
module pm_cap_regs_tb_top;
    localparam logic [5:0] CAP = 6'h10;
    localparam logic [5:0] CSR = 6'h11;
    localparam logic [5:0] INTD = 6'h0F;

    logic        clk = 1'b0;
    logic        pci_rst_n = 1'b0, aux_rst_n = 1'b0;
    logic        aux_present = 1'b1, wake_pulse = 1'b0, eeprom_valid = 1'b0;
    logic [7:0]  eeprom_min_grant = 8'h3A, eeprom_max_lat = 8'h7C;
    logic [5:0]  cfg_addr = 6'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_rdata;
    logic [1:0]  pwr_state;
    logic        pme_n, pme_oe;

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural reference state
    bit       m_sts = 0, m_en = 0;
    bit [1:0] m_ps = 0;
    bit [7:0] m_line = 0;

    always #4 clk = ~clk;

    pm_cap_regs dut_i (
        .clk(clk), .pci_rst_n(pci_rst_n), .aux_rst_n(aux_rst_n), .aux_present(aux_present),
        .wake_pulse(wake_pulse), .eeprom_valid(eeprom_valid),
        .eeprom_min_grant(eeprom_min_grant), .eeprom_max_lat(eeprom_max_lat),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr),
        .cfg_rdata(cfg_rdata), .pwr_state(pwr_state), .pme_n(pme_n), .pme_oe(pme_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // model: reset handling
    always @(negedge pci_rst_n) begin m_ps = 0; m_line = 0; end
    always @(negedge aux_rst_n) begin m_sts = 0; m_en = 0; end

    always @(posedge clk) begin
        bit [1:0] old_ps;
        bit wr_go;
        old_ps = m_ps;
        wr_go = cfg_wr && pci_rst_n;
        if (pci_rst_n && wr_go && cfg_be[0]) begin
            if (cfg_addr == CSR && (cfg_wdata[1:0] == 0 || cfg_wdata[1:0] == 3))
                m_ps = cfg_wdata[1:0];
            if (cfg_addr == INTD) m_line = cfg_wdata[7:0];
        end
        if (aux_rst_n) begin
            if (wr_go && cfg_addr == CSR && cfg_be[1]) begin
                m_en = cfg_wdata[8];
                if (cfg_wdata[15]) m_sts = 0;
            end
            if (wake_pulse && (aux_present || old_ps == 3)) m_sts = 1;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        logic [7:0] g, l;
        g = eeprom_valid ? eeprom_min_grant : 8'h20;
        l = eeprom_valid ? eeprom_max_lat : 8'h20;
        if (a == INTD) return {l, g, 8'h01, m_line};
        if (a == CAP)  return {aux_present ? 16'hC0A2 : 16'h4022, 16'h0001};
        if (a == CSR)  return {16'h0, m_sts, 6'b0, m_en, 6'b0, m_ps};
        return 32'h0;
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            string t;
            t = (cfg_addr == INTD) ? "R8 rdata" : (cfg_addr == CAP) ? "R2 rdata" :
                (cfg_addr == CSR) ? "R3 rdata" : "R6 rdata";
            chk(t, cfg_rdata, exp_rd(cfg_addr));
            chk("R5 pwr_state", {30'h0, pwr_state}, {30'h0, m_ps});
            chk("R9 pme_oe", {31'h0, pme_oe}, {31'h0, m_sts && m_en});
            chk("R9 pme_n", {31'h0, pme_n}, {31'h0, !(m_sts && m_en)});
        end
    end

    task automatic step(); @(negedge clk); #1; endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic wake();
        wake_pulse = 1'b1; step(); wake_pulse = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag, input logic [31:0] exp);
        cfg_addr = a;
        @(negedge clk);
        chk(tag, cfg_rdata, exp);
        #1;
    endtask

    initial begin
        #(8 * 20000);
        $display("FAIL watchdog: actual=timeout expected=completion");
        bad++; total++;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        pci_rst_n = 1'b1; aux_rst_n = 1'b1;
        step();
        rd(CAP,  "R1 header", 32'hC0A2_0001);
        rd(CSR,  "R7 reset csr", 32'h0);
        rd(INTD, "R8 defaults", 32'h2020_0100);
        rd(6'h05, "R6 unmapped", 32'h0);
        aux_present = 1'b0;
        rd(CAP, "R2 no aux", 32'h4022_0001);
        aux_present = 1'b1;
        eeprom_valid = 1'b1;
        rd(INTD, "R8 eeprom", 32'h7C3A_0100);
        wr(INTD, 4'b0001, 32'hFFFF_FF5A);
        wr(INTD, 4'b1110, 32'hFFFF_FFA5);
        rd(INTD, "R11 line be", 32'h7C3A_015A);
        // enable, then wake
        wr(CSR, 4'b0010, 32'hFFFF_7FFF);
        rd(CSR, "R6 zero bits", 32'h0000_0100);
        wake(); step();
        chk("R9 pme active", {31'h0, pme_oe}, 32'h1);
        wr(CSR, 4'b0010, 32'h0000_0100);
        rd(CSR, "R3 write0 keeps", 32'h0000_8100);
        wr(CSR, 4'b0001, 32'h0000_8100);
        rd(CSR, "R11 be1 off", 32'h0000_8100);
        wr(CSR, 4'b0010, 32'h0000_8000);
        rd(CSR, "R3 cleared", 32'h0);
        // wake with enable 0
        wake(); step();
        rd(CSR, "R4 sts without en", 32'h0000_8000);
        chk("R9 pme idle", {31'h0, pme_n}, 32'h1);
        wr(CSR, 4'b0010, 32'h0000_8000);
        // no aux, D0: ignored
        aux_present = 1'b0;
        wake(); step();
        rd(CSR, "R10 ignored in D0", 32'h0);
        wr(CSR, 4'b0001, 32'h0000_0003);
        wake(); step();
        rd(CSR, "R10 set in D3hot", 32'h0000_8003);
        wr(CSR, 4'b0010, 32'h0000_8000);
        wr(CSR, 4'b0001, 32'h0000_0001);
        rd(CSR, "R5 keep on 01", 32'h0000_0003);
        wr(CSR, 4'b0001, 32'h0000_0002);
        rd(CSR, "R5 keep on 10", 32'h0000_0003);
        aux_present = 1'b1;
        // simultaneous clear and wake
        cfg_addr = CSR; cfg_be = 4'b0010; cfg_wdata = 32'h0000_8100; cfg_wr = 1'b1;
        wake_pulse = 1'b1; step();
        cfg_wr = 1'b0; wake_pulse = 1'b0; cfg_be = 4'h0;
        rd(CSR, "R3 wake beats clear", 32'h0000_8103);
        wr(INTD, 4'b0001, 32'h0000_0033);
        // PCI reset: sticky kept, write ignored
        pci_rst_n = 1'b0;
        wr(CSR, 4'b0011, 32'h0000_8003);
        step();
        pci_rst_n = 1'b1; step();
        rd(CSR, "R7 sticky kept", 32'h0000_8100);
        rd(INTD, "R7 line reset", 32'h7C3A_0100);
        wr(CSR, 4'b0001, 32'h0000_0000);
        rd(CSR, "R5 D0 stored", 32'h0000_8100);
        aux_rst_n = 1'b0; step(); aux_rst_n = 1'b1; step();
        rd(CSR, "R7 aux reset", 32'h0);
        step();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule